// File: doc/BRIEF.md
# Fractional-Rate Master Time Counter

This block keeps a free-running 64-bit time count that advances at a constant rate whatever system clock feeds it. Every system clock cycle a programmable numerator is added into a phase accumulator. When the sum reaches the programmable denominator, the denominator is taken off and the count steps by one. The count rate is therefore the input clock rate times numerator over denominator. For example, 4/25 of 38.4 MHz gives 6.144 MHz, 64/125 of 12 MHz gives the same, and so does 256/1125 of 27 MHz.

A slow reference tick, nominally 32.768 kHz and arriving as a one-cycle pulse synchronous to the system clock, steps a coarse reference kept in half-count units. Each tick adds 375 half-counts, so two ticks are worth 375 fine counts. When correction is enabled, every tick overwrites the fine count with half the coarse value and clears the accumulator. This removes drift from the fine path. When the slow reference is itself made from the system clock divided by 610, software programs 75/244 so that both paths agree at clock / 610 × 375 / 2.

A small register port sets the fraction, enables correction and reads or loads the count. The count is read as two 32-bit words, and reading the low word captures the high word so that the pair is coherent.

Top module: `frac_time_counter`

## Requirements
- R1: After reset the count is 0 and the accumulator and coarse reference are 0. The numerator register (offset 0x10) reads 4, the denominator register (offset 0x14) reads 25 and the control register (offset 0x08) reads 0.
- R2: When the denominator is not zero, each cycle adds the numerator (bits 11:0 of 0x10) to the accumulator. If the sum is at least the denominator (bits 11:0 of 0x14), the denominator is subtracted and the count rises by one in that cycle. Starting from a cleared accumulator, k cycles therefore add floor(k·num/den) counts.
- R3: A numerator at or above the denominator gives exactly one count per cycle, never more.
- R4: A denominator of zero freezes both the count and the accumulator.
- R5: Writes to 0x10 and 0x14 store all 32 bits and read back unchanged. Only bits 11:0 steer counting, so a read-modify-write of bits 11:0 keeps bits 31:12.
- R6: Every tick pulse adds 375 to the coarse reference. When control bit 0 is 1, the same edge loads the count with the new coarse value divided by two and clears the accumulator.
- R7: With control bit 0 at 0, a tick leaves the count untouched.
- R8: When a tick with correction enabled meets a write to 0x00 or 0x04 in the same cycle, the tick load wins.
- R9: A write to 0x00 replaces count bits 31:0 and a write to 0x04 replaces bits 63:32, with no increment in that cycle.
- R10: A read strobe at 0x00 returns count bits 31:0 and captures bits 63:32 at that edge. Offset 0x04 returns the captured word, not the live one.
- R11: The fraction 75/244 yields exactly 750 counts per 2440 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_tick_i | input | 1 | One-cycle slow reference pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect only at 0x00) |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| count_o | output | 64 | Live time count |

## Verification
The bench builds the block with its default parameters: a 64-bit count, 12-bit fraction fields and a 375 half-count coarse step. With those values, every real fraction pair fits its field, including 768/1625, and the odd coarse step makes the divide-by-two truncation show after a single tick. Carry from the low word into the high word cannot be reached by counting inside a short run. The bench therefore reaches it by loading the count just below the word boundary with the denominator at zero, then setting one count per cycle.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int OFS_CNT_LO = 'h00;
    localparam int OFS_CNT_HI = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_NUM    = 'h10;
    localparam int OFS_DEN    = 'h14;
    localparam int HALF_STEP  = 375;
endpackage

// File: rtl/ftc_phase_step.sv
module ftc_phase_step #(
    parameter int FRAC_W = 12
) (
    input  logic [FRAC_W-1:0] acc_q_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    output logic [FRAC_W-1:0] acc_d_o,
    output logic              inc_o
);
    localparam int SUM_W = FRAC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;
    logic [SUM_W-1:0] den_x;

    always_comb begin
        den_x   = SUM_W'(den_i);
        sum     = SUM_W'(acc_q_i) + SUM_W'(num_i);
        rem     = sum - den_x;
        acc_d_o = acc_q_i;
        inc_o   = 1'b0;
        if (den_i != '0) begin
            if (sum >= den_x) begin
                inc_o = 1'b1;
                // clamp: at most one count per cycle, residue stays below den
                if (rem >= den_x) begin
                    acc_d_o = den_i - FRAC_W'(1);
                end else begin
                    acc_d_o = rem[FRAC_W-1:0];
                end
            end else begin
                acc_d_o = sum[FRAC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ftc_coarse_ref.sv
module ftc_coarse_ref #(
    parameter int COUNT_W = 64,
    parameter int STEP    = 375
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    output logic [COUNT_W-1:0] load_o
);
    localparam int HALF_W = COUNT_W + 1;

    logic [HALF_W-1:0] half_d, half_q, half_nx;

    always_comb begin
        half_nx = half_q + HALF_W'(STEP);
        half_d  = tick_i ? half_nx : half_q;
        load_o  = half_nx[HALF_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= half_d;
    end
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter #(
    parameter int COUNT_W = 64,
    parameter int REG_W   = 32,
    parameter int FRAC_W  = 12,
    parameter int ADDR_W  = 8,
    parameter int STEP    = ftc_pkg::HALF_STEP,
    parameter int RST_NUM = 4,
    parameter int RST_DEN = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coarse_tick_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic [COUNT_W-1:0] count_o
);
    import ftc_pkg::*;

    localparam int HI_W = COUNT_W - REG_W;

    typedef struct packed {
        logic [COUNT_W-1:0] count;
        logic [FRAC_W-1:0]  acc;
        logic [REG_W-1:0]   num_reg;
        logic [REG_W-1:0]   den_reg;
        logic               tick_en;
        logic [HI_W-1:0]    hi_latch;
    } state_t;

    state_t st_d, st_q;

    logic [FRAC_W-1:0]  acc_nx;
    logic               step_inc;
    logic [COUNT_W-1:0] coarse_load;
    logic               sel_lo, sel_hi, sel_ctl, sel_num, sel_den;
    logic [FRAC_W-1:0]  num_eff, den_eff;
    logic [HI_W-1:0]    hi_latch_w;

    assign num_eff    = st_q.num_reg[FRAC_W-1:0];
    assign den_eff    = st_q.den_reg[FRAC_W-1:0];
    assign hi_latch_w = st_q.hi_latch;

    ftc_phase_step #(.FRAC_W(FRAC_W)) u_step (
        .acc_q_i (st_q.acc),
        .num_i   (num_eff),
        .den_i   (den_eff),
        .acc_d_o (acc_nx),
        .inc_o   (step_inc)
    );

    ftc_coarse_ref #(.COUNT_W(COUNT_W), .STEP(STEP)) u_coarse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (coarse_tick_i),
        .load_o (coarse_load)
    );

    always_comb begin
        sel_lo  = (addr_i == ADDR_W'(OFS_CNT_LO));
        sel_hi  = (addr_i == ADDR_W'(OFS_CNT_HI));
        sel_ctl = (addr_i == ADDR_W'(OFS_CTRL));
        sel_num = (addr_i == ADDR_W'(OFS_NUM));
        sel_den = (addr_i == ADDR_W'(OFS_DEN));

        st_d     = st_q;
        st_d.acc = acc_nx;

        // count update, priority: correction tick, count write, increment
        if (coarse_tick_i && st_q.tick_en) begin
            st_d.count = coarse_load;
            st_d.acc   = '0;
        end else if (wr_en_i && sel_lo) begin
            st_d.count[REG_W-1:0] = wdata_i;
        end else if (wr_en_i && sel_hi) begin
            st_d.count[COUNT_W-1:REG_W] = wdata_i[HI_W-1:0];
        end else if (step_inc) begin
            st_d.count = st_q.count + COUNT_W'(1);
        end

        if (wr_en_i && sel_ctl) st_d.tick_en = wdata_i[0];
        if (wr_en_i && sel_num) st_d.num_reg = wdata_i;
        if (wr_en_i && sel_den) st_d.den_reg = wdata_i;

        if (rd_en_i && sel_lo) st_d.hi_latch = st_q.count[COUNT_W-1:REG_W];

        if (sel_lo)       rdata_o = st_q.count[REG_W-1:0];
        else if (sel_hi)  rdata_o = REG_W'(st_q.hi_latch);
        else if (sel_ctl) rdata_o = REG_W'(st_q.tick_en);
        else if (sel_num) rdata_o = st_q.num_reg;
        else if (sel_den) rdata_o = st_q.den_reg;
        else              rdata_o = '0;

        count_o = st_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count    <= '0;
            st_q.acc      <= '0;
            st_q.num_reg  <= REG_W'(RST_NUM);
            st_q.den_reg  <= REG_W'(RST_DEN);
            st_q.tick_en  <= 1'b0;
            st_q.hi_latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
    parameter int COUNT_W = 64,
    parameter int REG_W   = 32,
    parameter int FRAC_W  = 12,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [COUNT_W-1:0] count_o,
    input logic [FRAC_W-1:0]  num_w,
    input logic [FRAC_W-1:0]  den_w,
    input logic               tick_en_w,
    input logic [COUNT_W-1:0] load_w,
    input logic [COUNT_W-REG_W-1:0] hi_w
);
    logic cnt_wr;
    assign cnt_wr = wr_en_i && (addr_i == ADDR_W'(0) || addr_i == ADDR_W'(4));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr) |=> (count_o == $past(count_o) || count_o == $past(count_o) + COUNT_W'(1)));

    p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr && den_w != '0 && num_w >= den_w) |=> (count_o == $past(count_o) + COUNT_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr && den_w == '0) |=> $stable(count_o));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && tick_en_w) |=> (count_o == $past(load_w)));

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(0)) |=> (hi_w == $past(count_o[COUNT_W-1:REG_W])));
endmodule

bind frac_time_counter ftc_checker #(
    .COUNT_W(COUNT_W), .REG_W(REG_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (coarse_tick_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .count_o   (count_o),
    .num_w     (num_eff),
    .den_w     (den_eff),
    .tick_en_w (st_q.tick_en),
    .load_w    (coarse_load),
    .hi_w      (hi_latch_w)
);

// File: tb/tb_frac_time_counter.sv
`timescale 1ns/1ps
module tb_frac_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int n_ticks = 0;

    always #2 clk = ~clk;

    frac_time_counter dut (
        .clk(clk), .rst_n(rst_n), .coarse_tick_i(tick), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .count_o(count)
    );

    // behavioural reference model
    longint unsigned m_count, m_coarse;
    int m_acc, m_num, m_den;
    bit m_en;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_coarse = 0; m_acc = 0;
            m_num = 4; m_den = 25; m_en = 0;
        end else begin
            int n, d, s;
            bit inc;
            n = m_num & 'hfff;
            d = m_den & 'hfff;
            inc = 0;
            if (d != 0) begin
                s = m_acc + n;
                if (s >= d) begin
                    inc = 1;
                    m_acc = (s - d < d) ? s - d : d - 1;
                end else m_acc = s;
            end
            if (tick) m_coarse += 375;
            if (tick && m_en) begin
                m_count = m_coarse / 2;
                m_acc = 0;
            end else if (wr_en && addr == 8'h00) m_count = {m_count[63:32], wdata};
            else if (wr_en && addr == 8'h04) m_count = {wdata, m_count[31:0]};
            else if (inc) m_count += 1;
            if (wr_en && addr == 8'h08) m_en = wdata[0];
            if (wr_en && addr == 8'h10) m_num = int'(wdata);
            if (wr_en && addr == 8'h14) m_den = int'(wdata);
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) chk("R2 model", count, m_count);

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #0.5 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse();
        tick = 1'b1; n_ticks++;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_rate(int n, int d);
        wr(8'h14, 0);
        wr(8'h10, n);
        pulse();
        wr(8'h14, d);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, lo, hi;
        logic [63:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 count", count, 0);
        rd(8'h10, v); chk("R1 num", v, 4);
        rd(8'h14, v); chk("R1 den", v, 25);
        rd(8'h08, v); chk("R1 ctrl", v, 0);
        repeat (2497) @(negedge clk);
        chk("R2 4/25 rate", count, 400);

        wr(8'h08, 1);
        set_rate(64, 125);
        chk("R6 load", count, (375 * n_ticks) / 2);
        c0 = count;
        repeat (1250) @(negedge clk);
        chk("R2 64/125 rate", count, c0 + 640);

        set_rate(75, 244);
        c0 = count;
        repeat (2440) @(negedge clk);
        chk("R11 75/244 rate", count, c0 + 750);

        set_rate(10, 5);
        c0 = count;
        repeat (100) @(negedge clk);
        chk("R3 clamp", count, c0 + 100);

        wr(8'h14, 0);
        c0 = count;
        repeat (50) @(negedge clk);
        chk("R4 freeze", count, c0);

        wr(8'h08, 0);
        c0 = count;
        pulse();
        chk("R7 tick ignored", count, c0);
        wr(8'h08, 1);
        pulse();
        chk("R6 odd step", count, (375 * n_ticks) / 2);

        addr = 8'h00; wdata = 32'h1234; wr_en = 1'b1; tick = 1'b1; n_ticks++;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R8 tick wins", count, (375 * n_ticks) / 2);

        wr(8'h00, 32'hDEADBEEF);
        wr(8'h04, 32'h12);
        chk("R9 halves", count, 64'h12_DEADBEEF);

        wr(8'h10, 32'hABCDE040);
        rd(8'h10, v); chk("R5 readback", v, 32'hABCDE040);
        wr(8'h10, (v & 32'hFFFFF000) | 32'h300);
        rd(8'h10, v); chk("R5 rmw", v, 32'hABCDE300);

        wr(8'h00, 32'hFFFFFFFF);
        wr(8'h04, 0);
        wr(8'h10, 1);
        wr(8'h14, 1);
        rd(8'h00, lo);
        rd(8'h04, hi);
        chk("R10 coherent", {hi, lo}, 64'h0_FFFFFFFF);
        chk("R10 live moved", count, 64'h1_00000001);

        repeat (20) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule